// File: doc/BRIEF.md
# Low-Power Wake Sequencer

This block controls how a small processor core leaves its Sleep and Idle power states and returns to Run. While the core reports a low-power mode, the block watches three kinds of wake trigger: a restart request, a watchdog expiry, and interrupt flags that are individually enabled. When a trigger is captured, the block decides whether the primary oscillator was stopped and must be given its start-up wait. It then holds instruction execution through a fixed CPU settle interval. After that it emits a single-cycle resume pulse, with a code that tells the core where to continue.

Suppose the primary clock kept running (primary-clock Idle), or the primary source is not a crystal or PLL type. In that case the start-up wait is skipped and only the settle interval applies. An interrupt wake resumes in line or goes to the interrupt vector, depending on the global interrupt enable. A restart request always sends the core to address zero. A watchdog expiry during a low-power mode is a plain wake and continues in line. All delays are parameters: `SETTLE_CYCLES` defaults to 2 and `OSC_START_CYCLES` defaults to 1024.

Top module: `lp_wake_sequencer`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, exec_hold and resume_valid are 0.
- R2: When pwr_mode is 2'b00 (Run), no trigger of any kind starts a wake sequence: exec_hold and resume_valid stay 0.
- R3: An interrupt source wakes the block only when irq_flag[i] and irq_en[i] are both 1 for the same i. A flag whose enable is 0 has no effect.
- R4: An interrupt wake reports resume_code 2'b01 (vector) if gie was 1 on the capturing edge, and 2'b00 (continue in line) if gie was 0.
- R5: A watchdog wake reports resume_code 2'b00. A restart-request wake reports 2'b10 (restart at address zero).
- R6: When triggers coincide on the capturing edge, the restart request wins over the watchdog, and the watchdog wins over interrupts.
- R7: The oscillator start-up wait is skipped when pwr_mode is 2'b10 (primary-clock Idle) or osc_sel[2] is 1 (codes 4..7: RC, external clock or internal oscillator types). In that case resume_valid is 1 in the cycle that follows the SETTLE_CYCLES-th clock edge after the capturing edge.
- R8: When osc_sel[2] is 0 (codes 0..3: crystal and PLL types) and pwr_mode is 2'b01 (Sleep) or 2'b11 (Idle on a secondary clock), the start-up wait runs before the settle interval. resume_valid then follows the (OSC_START_CYCLES+SETTLE_CYCLES)-th edge after the capturing edge.
- R9: exec_hold is 1 in every cycle from the capturing edge until the resume edge, and 0 in the resume cycle.
- R10: resume_valid is 1 for exactly one cycle per wake, and resume_code is meaningful only in that cycle.
- R11: A restart request seen while a wake is waiting changes the reported code to 2'b10 without changing the resume cycle. Other triggers seen while waiting change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_mode | input | 2 | Power mode: 00 Run, 01 Sleep, 10 primary-clock Idle, 11 secondary-clock Idle |
| osc_sel | input | 3 | Primary oscillator type; bit 2 = 0 means crystal or PLL type |
| irq_flag | input | N_IRQ | Interrupt flag bits |
| irq_en | input | N_IRQ | Interrupt enable bits |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog expiry strobe |
| reset_req | input | 1 | Restart request trigger |
| exec_hold | output | 1 | Instruction execution held while waking |
| resume_valid | output | 1 | One-cycle resume pulse |
| resume_code | output | 2 | 00 in line, 01 vector, 10 restart at zero |

## Verification
Suppose the internal wait counter were loaded with the wrong value, or the wait phases were entered in the wrong order. The resume pulse would then move by whole cycles: by up to a thousand cycles in the start-up case, and by one or two in the bypass case. Measuring the edge distance from trigger to pulse exposes this on the first wake. A latched cause that is wrong shows only in resume_code on the pulse cycle. A state machine stuck outside its waiting state shows as exec_hold staying high, or as a missing or repeated pulse, within a few cycles of the expected resume.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;

   typedef enum logic [1:0] {
      PM_RUN      = 2'b00,
      PM_SLEEP    = 2'b01,
      PM_PRI_IDLE = 2'b10,
      PM_SEC_IDLE = 2'b11
   } pwr_mode_t;

   typedef enum logic [1:0] {
      RC_INLINE  = 2'b00,
      RC_VECTOR  = 2'b01,
      RC_RESTART = 2'b10
   } resume_code_t;

   typedef enum logic [1:0] {
      WS_WATCH  = 2'b00,
      WS_OSC    = 2'b01,
      WS_SETTLE = 2'b10,
      WS_RESUME = 2'b11
   } wake_state_t;

   function automatic logic needs_osc_wait(input logic [1:0] mode, input logic [2:0] osc);
      return (osc[2] == 1'b0) && (mode == PM_SLEEP || mode == PM_SEC_IDLE);
   endfunction

endpackage

// File: rtl/wake_trigger_arbiter.sv
module wake_trigger_arbiter
   import lp_wake_pkg::*;
#(
   parameter int N_IRQ = 8
) (
   input  logic [N_IRQ-1:0] irq_flag,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             gie,
   input  logic             wdt_timeout,
   input  logic             reset_req,
   output logic             any_trigger,
   output resume_code_t     code
);

   logic irq_hit;

   generate
      if (N_IRQ == 1) begin : g_single
         assign irq_hit = irq_flag[0] & irq_en[0];
      end else begin : g_tree
         logic [N_IRQ-1:0] chain;
         assign chain[0] = irq_flag[0] & irq_en[0];
         for (genvar i = 1; i < N_IRQ; i++) begin : g_or
            assign chain[i] = chain[i-1] | (irq_flag[i] & irq_en[i]);
         end
         assign irq_hit = chain[N_IRQ-1];
      end
   endgenerate

   always_comb begin
      any_trigger = reset_req | wdt_timeout | irq_hit;
      if (reset_req)        code = RC_RESTART;
      else if (wdt_timeout) code = RC_INLINE;
      else if (gie)         code = RC_VECTOR;
      else                  code = RC_INLINE;
   end

   always_comb begin
      if (reset_req) assert_restart_wins_R6: assert (code == RC_RESTART);
   end

endmodule

// File: rtl/wake_cycle_timer.sv
module wake_cycle_timer #(
   parameter int WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             expired
);

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   assert_expiry_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);

endmodule

// File: rtl/lp_wake_sequencer.sv
module lp_wake_sequencer
   import lp_wake_pkg::*;
#(
   parameter int N_IRQ            = 8,
   parameter int SETTLE_CYCLES    = 2,
   parameter int OSC_START_CYCLES = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       pwr_mode,
   input  logic [2:0]       osc_sel,
   input  logic [N_IRQ-1:0] irq_flag,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             gie,
   input  logic             wdt_timeout,
   input  logic             reset_req,
   output logic             exec_hold,
   output logic             resume_valid,
   output logic [1:0]       resume_code
);

   localparam int MAX_WAIT = (OSC_START_CYCLES > SETTLE_CYCLES) ? OSC_START_CYCLES : SETTLE_CYCLES;
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);
   localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);
   localparam logic [CNT_W-1:0] OSC_LOAD    = CNT_W'(OSC_START_CYCLES - 1);

   generate
      if (N_IRQ < 1)            begin : g_bad_irq    $error("N_IRQ must be at least 1");            end
      if (SETTLE_CYCLES < 1)    begin : g_bad_settle $error("SETTLE_CYCLES must be at least 1");    end
      if (OSC_START_CYCLES < 1) begin : g_bad_osc    $error("OSC_START_CYCLES must be at least 1"); end
   endgenerate

   wake_state_t      state_q, state_d;
   resume_code_t     cause_q, cause_d;
   resume_code_t     arb_code;
   logic             arb_hit;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;

   wake_trigger_arbiter #(.N_IRQ(N_IRQ)) u_arb (
      .irq_flag    (irq_flag),
      .irq_en      (irq_en),
      .gie         (gie),
      .wdt_timeout (wdt_timeout),
      .reset_req   (reset_req),
      .any_trigger (arb_hit),
      .code        (arb_code)
   );

   wake_cycle_timer #(.WIDTH(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_comb begin
      state_d  = state_q;
      cause_d  = cause_q;
      tmr_load = 1'b0;
      tmr_val  = SETTLE_LOAD;
      unique case (state_q)
         WS_WATCH: begin
            if (pwr_mode != PM_RUN && arb_hit) begin
               cause_d  = arb_code;
               tmr_load = 1'b1;
               if (needs_osc_wait(pwr_mode, osc_sel)) begin
                  state_d = WS_OSC;
                  tmr_val = OSC_LOAD;
               end else begin
                  state_d = WS_SETTLE;
               end
            end
         end
         WS_OSC: begin
            if (reset_req) cause_d = RC_RESTART;
            if (tmr_expired) begin
               state_d  = WS_SETTLE;
               tmr_load = 1'b1;
            end
         end
         WS_SETTLE: begin
            if (reset_req) cause_d = RC_RESTART;
            if (tmr_expired) state_d = WS_RESUME;
         end
         WS_RESUME: state_d = WS_WATCH;
         default:   state_d = WS_WATCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_WATCH;
         cause_q <= RC_INLINE;
      end else begin
         state_q <= state_d;
         cause_q <= cause_d;
      end
   end

   assign exec_hold    = (state_q == WS_OSC) || (state_q == WS_SETTLE);
   assign resume_valid = (state_q == WS_RESUME);
   assign resume_code  = cause_q;

   assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resume_valid |=> !resume_valid);
   assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resume_valid |-> (resume_code != 2'b11));
   assert_run_stays_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_hold && !resume_valid && pwr_mode == PM_RUN) |=> !exec_hold);
   assert_hold_excludes_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_hold && resume_valid));
   assert_restart_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_hold && reset_req) |=> (resume_code == RC_RESTART));

endmodule

// File: tb/tb_lp_wake_sequencer.sv
module tb_lp_wake_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int N_IRQ      = 8;
   localparam int SETTLE     = 2;
   localparam int OSC_START  = 1024;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [1:0]       pwr_mode;
   logic [2:0]       osc_sel;
   logic [N_IRQ-1:0] irq_flag, irq_en;
   logic             gie, wdt_timeout, reset_req;
   logic             exec_hold, resume_valid;
   logic [1:0]       resume_code;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lp_wake_sequencer #(.N_IRQ(N_IRQ), .SETTLE_CYCLES(SETTLE), .OSC_START_CYCLES(OSC_START)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .osc_sel(osc_sel),
      .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .wdt_timeout(wdt_timeout),
      .reset_req(reset_req), .exec_hold(exec_hold), .resume_valid(resume_valid),
      .resume_code(resume_code)
   );

   task automatic expect_eq(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      pwr_mode = 2'b00; osc_sel = 3'd4; irq_flag = '0; irq_en = '0;
      gie = 1'b0; wdt_timeout = 1'b0; reset_req = 1'b0;
   endtask

   // Triggers must be driven at a negedge before the call; one edge later they are captured.
   task automatic await_resume(input string req, input int exp_lat, input int exp_code,
                               input bit pulse_reset_mid);
      int  lat = 0;
      bit  hold_ok = 1'b1;
      forever begin
         @(negedge clk);
         lat++;
         wdt_timeout = 1'b0;
         reset_req   = 1'b0;
         if (pulse_reset_mid && lat == 5) reset_req = 1'b1;
         if (resume_valid || lat > OSC_START + 50) break;
         if (!exec_hold) hold_ok = 1'b0;
      end
      expect_eq({req, " latency"}, lat, exp_lat + 1);
      expect_eq({req, " code"}, resume_code, exp_code);
      expect_eq("R9 hold during wait", hold_ok, 1);
      expect_eq("R9 hold low on resume", exec_hold, 0);
      clear_inputs();
      @(negedge clk);
      expect_eq("R10 pulse single cycle", resume_valid, 0);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      clear_inputs();
      rst_n = 1'b0;
      #(CLK_PERIOD*3);
      @(negedge clk);
      expect_eq("R1 hold in reset", exec_hold, 0);
      expect_eq("R1 pulse in reset", resume_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_eq("R1 hold after reset", exec_hold, 0);
      expect_eq("R1 pulse after reset", resume_valid, 0);
   endtask

   task automatic t_run_ignores();
      bit seen = 1'b0;
      clear_inputs();
      irq_flag = 8'h01; irq_en = 8'h01; gie = 1'b1;
      wdt_timeout = 1'b1; reset_req = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (exec_hold || resume_valid) seen = 1'b1;
      end
      expect_eq("R2 run mode ignores triggers", seen, 0);
      clear_inputs();
   endtask

   task automatic t_disabled_irq();
      bit seen = 1'b0;
      clear_inputs();
      pwr_mode = 2'b01; irq_flag = 8'hF0; irq_en = 8'h0F; gie = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (exec_hold || resume_valid) seen = 1'b1;
      end
      expect_eq("R3 disabled flags ignored", seen, 0);
      clear_inputs();
   endtask

   task automatic t_irq_vector_bypass();
      @(negedge clk);
      pwr_mode = 2'b01; osc_sel = 3'd6; irq_flag = 8'h20; irq_en = 8'h20; gie = 1'b1;
      await_resume("R4 R7 irq vector bypass", SETTLE, 1, 1'b0);
   endtask

   task automatic t_irq_inline_osc();
      @(negedge clk);
      pwr_mode = 2'b01; osc_sel = 3'd2; irq_flag = 8'h81; irq_en = 8'h80; gie = 1'b0;
      await_resume("R3 R4 R8 irq inline osc wait", OSC_START + SETTLE, 0, 1'b0);
   endtask

   task automatic t_pri_idle_bypass();
      @(negedge clk);
      pwr_mode = 2'b10; osc_sel = 3'd2; irq_flag = 8'h02; irq_en = 8'h02; gie = 1'b1;
      await_resume("R7 primary idle bypass", SETTLE, 1, 1'b0);
   endtask

   task automatic t_wdt_sec_idle();
      @(negedge clk);
      pwr_mode = 2'b11; osc_sel = 3'd1; wdt_timeout = 1'b1;
      await_resume("R5 R8 watchdog wake", OSC_START + SETTLE, 0, 1'b0);
   endtask

   task automatic t_restart_wake();
      @(negedge clk);
      pwr_mode = 2'b01; osc_sel = 3'd5; reset_req = 1'b1;
      await_resume("R5 restart wake", SETTLE, 2, 1'b0);
   endtask

   task automatic t_priority();
      @(negedge clk);
      pwr_mode = 2'b01; osc_sel = 3'd7; reset_req = 1'b1; wdt_timeout = 1'b1;
      irq_flag = 8'h01; irq_en = 8'h01; gie = 1'b1;
      await_resume("R6 restart over all", SETTLE, 2, 1'b0);
      pwr_mode = 2'b01; osc_sel = 3'd7; wdt_timeout = 1'b1;
      irq_flag = 8'h01; irq_en = 8'h01; gie = 1'b1;
      await_resume("R6 watchdog over irq", SETTLE, 0, 1'b0);
   endtask

   task automatic t_restart_upgrade();
      @(negedge clk);
      pwr_mode = 2'b01; osc_sel = 3'd0; irq_flag = 8'h04; irq_en = 8'h04; gie = 1'b1;
      await_resume("R11 restart during wait", OSC_START + SETTLE, 2, 1'b1);
   endtask

   task automatic t_late_trigger_ignored();
      @(negedge clk);
      pwr_mode = 2'b01; osc_sel = 3'd4; irq_flag = 8'h01; irq_en = 8'h01; gie = 1'b0;
      @(negedge clk);
      wdt_timeout = 1'b1; gie = 1'b1;
      await_resume("R11 late trigger no effect", SETTLE - 1, 0, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_run_ignores();
      t_disabled_irq();
      t_irq_vector_bypass();
      t_irq_inline_osc();
      t_pri_idle_bypass();
      t_wdt_sec_idle();
      t_restart_wake();
      t_priority();
      t_restart_upgrade();
      t_late_trigger_ignored();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule